// File: doc/BRIEF.md
# I2C Status Flags and Clock-Stretch Control

This block keeps the four event flags of a byte-oriented I2C controller and turns them into a status byte, a level interrupt request and a request to hold SCL low. The bit-level engine reports events to it as single-cycle strobes: an acknowledge pulse (with the byte's direction and whether it was an address byte), the address-acknowledged event, an own-address or general-call match, start generated, stop detected and arbitration lost. The CPU side reports reads of the status register, reads and writes of the data register, and writes of START=1.

Software clears the flags by access sequences. The match flag clears on a status read alone. The transfer-finished and start flags need two steps: a status read while the flag is set, then a qualifying data-register access. An internal armed bit links the two steps. While the transfer-finished or match flag is set, the block asks the bus engine to stretch the clock. Taking the peripheral enable low wipes every flag and every armed bit.

Top module: `i2c_sflag_top`

## Requirements
- R1: `status_o` has bit 3 = byte-transfer-finished, bit 2 = address-matched, bit 1 = master mode, bit 0 = start-generated. All higher bits read 0, and all bits are 0 after reset.
- R2: Byte-transfer-finished reads 1 in the cycle after any of these: an ack pulse on a transmitted data byte (`byte_tx_i`=1, `byte_addr_i`=0); an ack pulse on a received byte while `ack_en_i`=1; `addr_ack_i`. An ack pulse on a transmitted address byte does not set it, and neither does a received byte while `ack_en_i`=0.
- R3: Byte-transfer-finished clears in the cycle after a data-register read or write, provided a status read while it was set came in an earlier cycle. A data-register access with no such prior read leaves it set.
- R4: Address-matched sets after `addr_match_i` or `gen_call_i` and clears in the cycle after a status read alone.
- R5: Master mode sets after `start_wr_i` and clears after `stop_det_i` or `arb_lost_i`.
- R6: Start-generated sets after `start_gen_i`. It clears only after a status read followed, in a later cycle, by a data-register write. A data-register read does not clear it.
- R7: `scl_hold_o` is 1 exactly while byte-transfer-finished or address-matched is 1.
- R8: `irq_o` is a level equal to `ite_i` AND (byte-transfer-finished OR address-matched OR start-generated).
- R9: With `pe_i`=0, all four flags read 0 from the next cycle on. Set strobes are ignored, and any armed clear step is discarded.
- R10: A set strobe in the same cycle as a clear condition for the same flag leaves the flag set.
- R11: If a flag sets again between the status read and the data-register access, that access does not clear it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| pe_i | input | 1 | Peripheral enable |
| ite_i | input | 1 | Interrupt enable |
| ack_en_i | input | 1 | Acknowledge enable for received bytes |
| start_wr_i | input | 1 | Software writes START=1 |
| ack_pulse_i | input | 1 | Ack clock pulse completed |
| byte_tx_i | input | 1 | Current byte is transmitted (1) or received (0) |
| byte_addr_i | input | 1 | Current byte is an address byte |
| addr_ack_i | input | 1 | Address byte acknowledged event |
| addr_match_i | input | 1 | Received address equals own address |
| gen_call_i | input | 1 | General call recognised |
| start_gen_i | input | 1 | Start condition produced |
| stop_det_i | input | 1 | Stop condition detected |
| arb_lost_i | input | 1 | Arbitration lost |
| sr_rd_i | input | 1 | Status register read |
| dr_rd_i | input | 1 | Data register read |
| dr_wr_i | input | 1 | Data register write |
| status_o | output | SR_W | Status byte |
| irq_o | output | 1 | Interrupt request level |
| scl_hold_o | output | 1 | Hold SCL low request |

## Verification
The collision that matters is a flag's set strobe landing in the same cycle as its clearing access, or between the two steps of its clear. Random stimulus fires set strobes, status reads and data accesses often enough that these collisions happen many times over. Directed cases also place an ack pulse exactly on the data write that completes an armed clear, and a fresh set between the read and the access. A bench model updated from the requirements judges every cycle's status, hold and interrupt. The flag must survive each such case, and the next data access must not clear it unless a new status read came first.

// File: rtl/i2c_sflag_pkg.sv
package i2c_sflag_pkg;
  localparam int unsigned BIT_SB   = 0;
  localparam int unsigned BIT_MSL  = 1;
  localparam int unsigned BIT_ADSL = 2;
  localparam int unsigned BIT_BTF  = 3;
  localparam int unsigned N_FLAGS  = 4;

  typedef struct packed {
    logic btf;
    logic adsl;
    logic msl;
    logic sb;
  } flags_t;
endpackage

// File: rtl/i2c_sflag_evt.sv
module i2c_sflag_evt (
  input  logic ack_pulse_i,
  input  logic byte_tx_i,
  input  logic byte_addr_i,
  input  logic ack_en_i,
  input  logic addr_ack_i,
  input  logic addr_match_i,
  input  logic gen_call_i,
  input  logic stop_det_i,
  input  logic arb_lost_i,
  output logic btf_set_o,
  output logic adsl_set_o,
  output logic msl_clr_o
);
  logic tx_data_done, rx_done;

  // address bytes finish through the address-acknowledged event, not the ack pulse
  assign tx_data_done = ack_pulse_i & byte_tx_i & ~byte_addr_i;
  assign rx_done      = ack_pulse_i & ~byte_tx_i & ack_en_i;
  assign btf_set_o    = tx_data_done | rx_done | addr_ack_i;
  assign adsl_set_o   = addr_match_i | gen_call_i;
  assign msl_clr_o    = stop_det_i | arb_lost_i;
endmodule

// File: rtl/i2c_sflag_bit.sv
module i2c_sflag_bit #(
  parameter bit TWO_STEP = 1'b0,
  parameter bit RD_CLR   = 1'b0
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic en_i,
  input  logic set_i,
  input  logic clr_i,
  input  logic rd_i,
  input  logic acc_i,
  output logic flag_o
);
  logic flag_q, arm_q;
  logic rd_clr, step_clr;

  assign rd_clr   = RD_CLR & rd_i;
  assign step_clr = TWO_STEP & arm_q & acc_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      flag_q <= 1'b0;
      arm_q  <= 1'b0;
    end else if (!en_i) begin
      flag_q <= 1'b0;
      arm_q  <= 1'b0;
    end else if (set_i) begin
      // set wins and discards any pending first step
      flag_q <= 1'b1;
      arm_q  <= 1'b0;
    end else if (clr_i || rd_clr || step_clr) begin
      flag_q <= 1'b0;
      arm_q  <= 1'b0;
    end else if (TWO_STEP && rd_i && flag_q) begin
      arm_q  <= 1'b1;
    end
  end

  assign flag_o = flag_q;

  p_set_wins_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (en_i && set_i) |=> flag_o);

  p_pe_clear_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !en_i |=> !flag_o);

  p_arm_needs_flag_r11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    arm_q |-> flag_o);

  if (TWO_STEP) begin : g_two_step
    p_single_access_keeps_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (en_i && flag_o && !arm_q && !clr_i && !rd_clr) |=> flag_o);
  end
endmodule

// File: rtl/i2c_sflag_out.sv
module i2c_sflag_out
  import i2c_sflag_pkg::*;
#(
  parameter int unsigned SR_W = 8
) (
  input  flags_t            flags_i,
  input  logic              ite_i,
  output logic [SR_W-1:0]   status_o,
  output logic              irq_o,
  output logic              scl_hold_o
);
  localparam int unsigned PAD_W = SR_W - N_FLAGS;

  always_comb begin
    status_o           = '0;
    status_o[BIT_BTF]  = flags_i.btf;
    status_o[BIT_ADSL] = flags_i.adsl;
    status_o[BIT_MSL]  = flags_i.msl;
    status_o[BIT_SB]   = flags_i.sb;
  end

  assign irq_o      = ite_i & (flags_i.btf | flags_i.adsl | flags_i.sb);
  assign scl_hold_o = flags_i.btf | flags_i.adsl;

  initial begin
    a_width_r1: assert (PAD_W < SR_W);
  end
endmodule

// File: rtl/i2c_sflag_top.sv
module i2c_sflag_top
  import i2c_sflag_pkg::*;
#(
  parameter int unsigned SR_W = 8
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            pe_i,
  input  logic            ite_i,
  input  logic            ack_en_i,
  input  logic            start_wr_i,
  input  logic            ack_pulse_i,
  input  logic            byte_tx_i,
  input  logic            byte_addr_i,
  input  logic            addr_ack_i,
  input  logic            addr_match_i,
  input  logic            gen_call_i,
  input  logic            start_gen_i,
  input  logic            stop_det_i,
  input  logic            arb_lost_i,
  input  logic            sr_rd_i,
  input  logic            dr_rd_i,
  input  logic            dr_wr_i,
  output logic [SR_W-1:0] status_o,
  output logic            irq_o,
  output logic            scl_hold_o
);
  flags_t flags;
  logic   btf_set, adsl_set, msl_clr, dr_acc;

  assign dr_acc = dr_rd_i | dr_wr_i;

  i2c_sflag_evt u_evt (
    .ack_pulse_i  (ack_pulse_i),
    .byte_tx_i    (byte_tx_i),
    .byte_addr_i  (byte_addr_i),
    .ack_en_i     (ack_en_i),
    .addr_ack_i   (addr_ack_i),
    .addr_match_i (addr_match_i),
    .gen_call_i   (gen_call_i),
    .stop_det_i   (stop_det_i),
    .arb_lost_i   (arb_lost_i),
    .btf_set_o    (btf_set),
    .adsl_set_o   (adsl_set),
    .msl_clr_o    (msl_clr)
  );

  i2c_sflag_bit #(.TWO_STEP(1'b1), .RD_CLR(1'b0)) u_btf (
    .clk_i (clk_i), .rst_ni (rst_ni), .en_i (pe_i),
    .set_i (btf_set), .clr_i (1'b0), .rd_i (sr_rd_i), .acc_i (dr_acc),
    .flag_o (flags.btf)
  );

  i2c_sflag_bit #(.TWO_STEP(1'b0), .RD_CLR(1'b1)) u_adsl (
    .clk_i (clk_i), .rst_ni (rst_ni), .en_i (pe_i),
    .set_i (adsl_set), .clr_i (1'b0), .rd_i (sr_rd_i), .acc_i (1'b0),
    .flag_o (flags.adsl)
  );

  i2c_sflag_bit #(.TWO_STEP(1'b0), .RD_CLR(1'b0)) u_msl (
    .clk_i (clk_i), .rst_ni (rst_ni), .en_i (pe_i),
    .set_i (start_wr_i), .clr_i (msl_clr), .rd_i (1'b0), .acc_i (1'b0),
    .flag_o (flags.msl)
  );

  i2c_sflag_bit #(.TWO_STEP(1'b1), .RD_CLR(1'b0)) u_sb (
    .clk_i (clk_i), .rst_ni (rst_ni), .en_i (pe_i),
    .set_i (start_gen_i), .clr_i (1'b0), .rd_i (sr_rd_i), .acc_i (dr_wr_i),
    .flag_o (flags.sb)
  );

  i2c_sflag_out #(.SR_W(SR_W)) u_out (
    .flags_i    (flags),
    .ite_i      (ite_i),
    .status_o   (status_o),
    .irq_o      (irq_o),
    .scl_hold_o (scl_hold_o)
  );

  p_match_stretch_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (pe_i && (addr_match_i || gen_call_i)) |=> scl_hold_o);

  p_irq_masked_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !ite_i |-> !irq_o);

  p_stop_ends_master_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (pe_i && (stop_det_i || arb_lost_i) && !start_wr_i) |=> !status_o[BIT_MSL]);

  p_addr_byte_no_btf_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (pe_i && !status_o[BIT_BTF] && ack_pulse_i && byte_tx_i && byte_addr_i && !addr_ack_i)
      |=> !status_o[BIT_BTF]);
endmodule

// File: tb/sim_i2c_sflag_top.sv
`timescale 1ns/1ps
module sim_i2c_sflag_top;
  localparam int unsigned SR_W = 8;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic pe, ite, ack_en, start_wr, ack_pulse, byte_tx, byte_addr, addr_ack;
  logic addr_match, gen_call, start_gen, stop_det, arb_lost, sr_rd, dr_rd, dr_wr;
  logic [SR_W-1:0] status;
  logic irq, scl_hold;

  int n_run = 0;
  int n_fail = 0;

  // bench model state
  logic m_btf, m_adsl, m_msl, m_sb, m_abtf, m_asb;

  always #2 clk = ~clk;

  i2c_sflag_top #(.SR_W(SR_W)) u0 (
    .clk_i (clk), .rst_ni (rst_n), .pe_i (pe), .ite_i (ite), .ack_en_i (ack_en),
    .start_wr_i (start_wr), .ack_pulse_i (ack_pulse), .byte_tx_i (byte_tx),
    .byte_addr_i (byte_addr), .addr_ack_i (addr_ack), .addr_match_i (addr_match),
    .gen_call_i (gen_call), .start_gen_i (start_gen), .stop_det_i (stop_det),
    .arb_lost_i (arb_lost), .sr_rd_i (sr_rd), .dr_rd_i (dr_rd), .dr_wr_i (dr_wr),
    .status_o (status), .irq_o (irq), .scl_hold_o (scl_hold)
  );

  function automatic logic [SR_W-1:0] exp_status();
    logic [SR_W-1:0] s = '0;
    s[3] = m_btf; s[2] = m_adsl; s[1] = m_msl; s[0] = m_sb;
    return s;
  endfunction

  function automatic logic exp_irq();
    return ite & (m_btf | m_adsl | m_sb);
  endfunction

  function automatic logic exp_hold();
    return m_btf | m_adsl;
  endfunction

  function automatic logic btf_event();
    return (ack_pulse & byte_tx & ~byte_addr) | (ack_pulse & ~byte_tx & ack_en) | addr_ack;
  endfunction

  task automatic check(string req, logic [31:0] act, logic [31:0] exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %0h expected %0h at %0t", req, act, exp, $time);
    end
  endtask

  task automatic model_reset();
    m_btf = 0; m_adsl = 0; m_msl = 0; m_sb = 0; m_abtf = 0; m_asb = 0;
  endtask

  // one clock edge of the requirement model, inputs as sampled
  task automatic step_model();
    logic s_btf, s_adsl, s_sb;
    if (!pe) begin
      model_reset();
      return;
    end
    s_btf = btf_event(); s_adsl = addr_match | gen_call; s_sb = start_gen;
    // byte-transfer-finished (R2, R3, R10, R11)
    if (s_btf) begin m_btf = 1; m_abtf = 0; end
    else if (m_abtf && (dr_rd || dr_wr)) begin m_btf = 0; m_abtf = 0; end
    else if (sr_rd && m_btf) m_abtf = 1;
    // address matched (R4)
    if (s_adsl) m_adsl = 1;
    else if (sr_rd) m_adsl = 0;
    // master mode (R5)
    if (start_wr) m_msl = 1;
    else if (stop_det || arb_lost) m_msl = 0;
    // start generated (R6)
    if (s_sb) begin m_sb = 1; m_asb = 0; end
    else if (m_asb && dr_wr) begin m_sb = 0; m_asb = 0; end
    else if (sr_rd && m_sb) m_asb = 1;
  endtask

  task automatic idle_strobes();
    start_wr = 0; ack_pulse = 0; byte_tx = 0; byte_addr = 0; addr_ack = 0;
    addr_match = 0; gen_call = 0; start_gen = 0; stop_det = 0; arb_lost = 0;
    sr_rd = 0; dr_rd = 0; dr_wr = 0;
  endtask

  // edge, model update, then compare at the falling edge
  task automatic tick();
    @(posedge clk);
    step_model();
    @(negedge clk);
    check("R1 status", status, exp_status());
    check("R7 hold", scl_hold, exp_hold());
    check("R8 irq", irq, exp_irq());
    idle_strobes();
  endtask

  task automatic clear_all();
    pe = 0; tick(); pe = 1; tick();
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog: actual timeout expected finish");
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    void'($urandom(32'h5eed_1c2a));
    idle_strobes();
    pe = 1; ite = 1; ack_en = 1;
    model_reset();
    repeat (3) @(negedge clk);
    check("R1 reset status", status, 0);
    check("R7 reset hold", scl_hold, 0);
    check("R8 reset irq", irq, 0);
    rst_n = 1;
    @(negedge clk);

    // R2: transmitted data byte
    ack_pulse = 1; byte_tx = 1; tick();
    check("R2 tx data sets btf", status, 8'h08);
    check("R7 btf holds scl", scl_hold, 1);
    check("R8 btf irq", irq, 1);
    // R3: access without read keeps it
    dr_rd = 1; tick();
    check("R3 dr access alone", status[3], 1);
    sr_rd = 1; tick();
    check("R3 after read", status[3], 1);
    dr_wr = 1; tick();
    check("R3 two-step clears", status[3], 0);

    // R2: address byte ack pulse ignored, address-ack event sets
    ack_pulse = 1; byte_tx = 1; byte_addr = 1; tick();
    check("R2 addr byte no btf", status[3], 0);
    addr_ack = 1; tick();
    check("R2 addr ack sets btf", status[3], 1);
    clear_all();

    // R2: receive needs ack_en
    ack_en = 0; ack_pulse = 1; byte_tx = 0; tick();
    check("R2 rx without ack", status[3], 0);
    ack_en = 1; ack_pulse = 1; byte_tx = 0; tick();
    check("R2 rx with ack", status[3], 1);
    clear_all();

    // R4
    gen_call = 1; tick();
    check("R4 general call", status, 8'h04);
    check("R7 match holds scl", scl_hold, 1);
    sr_rd = 1; tick();
    check("R4 read clears", status[2], 0);
    addr_match = 1; tick();
    check("R4 own address", status[2], 1);
    sr_rd = 1; tick();

    // R5 / R6
    start_wr = 1; tick();
    check("R5 master set", status[1], 1);
    start_gen = 1; tick();
    check("R6 start set", status, 8'h03);
    check("R7 start no hold", scl_hold, 0);
    sr_rd = 1; tick();
    dr_rd = 1; tick();
    check("R6 dr read keeps sb", status[0], 1);
    dr_wr = 1; tick();
    check("R6 write clears sb", status[0], 0);
    check("R5 master survives", status[1], 1);
    stop_det = 1; tick();
    check("R5 stop clears", status[1], 0);
    start_wr = 1; tick();
    arb_lost = 1; tick();
    check("R5 arb lost clears", status[1], 0);

    // R10: set in same cycle as clearing access
    ack_pulse = 1; byte_tx = 1; tick();
    sr_rd = 1; tick();
    dr_wr = 1; ack_pulse = 1; byte_tx = 1; tick();
    check("R10 set beats clear", status[3], 1);
    start_wr = 1; stop_det = 1; tick();
    check("R10 master set beats stop", status[1], 1);
    gen_call = 1; sr_rd = 1; tick();
    check("R10 match beats read", status[2], 1);
    clear_all();

    // R11: re-set between read and access
    ack_pulse = 1; byte_tx = 1; tick();
    sr_rd = 1; tick();
    addr_ack = 1; tick();
    dr_rd = 1; tick();
    check("R11 rearm discarded", status[3], 1);

    // R8 mask
    ite = 0; tick();
    check("R8 masked irq", irq, 0);
    ite = 1;

    // R9
    sr_rd = 1; start_wr = 1; tick();
    pe = 0; tick();
    check("R9 pe low clears", status, 0);
    addr_match = 1; start_gen = 1; ack_pulse = 1; byte_tx = 1; tick();
    check("R9 strobes ignored", status, 0);
    pe = 1; ack_pulse = 1; byte_tx = 1; tick();
    dr_rd = 1; tick();
    check("R9 arm discarded", status[3], 1);
    clear_all();

    // random phase
    for (int i = 0; i < 4000; i++) begin
      pe         = ($urandom % 40) != 0;
      ite        = ($urandom % 4) != 0;
      ack_en     = ($urandom % 3) != 0;
      ack_pulse  = ($urandom % 6) == 0;
      byte_tx    = $urandom % 2;
      byte_addr  = ($urandom % 3) == 0;
      addr_ack   = ($urandom % 12) == 0;
      addr_match = ($urandom % 14) == 0;
      gen_call   = ($urandom % 20) == 0;
      start_wr   = ($urandom % 10) == 0;
      start_gen  = ($urandom % 10) == 0;
      stop_det   = ($urandom % 10) == 0;
      arb_lost   = ($urandom % 25) == 0;
      sr_rd      = ($urandom % 3) == 0;
      dr_rd      = ($urandom % 4) == 0;
      dr_wr      = ($urandom % 4) == 0;
      tick();
    end

    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule